// File: doc/BRIEF.md
# Interrupting Byte Input Port

This block sits on a 16-bit-data processor bus as a read-only byte port. A user-side source presents an 8-bit character together with a one-cycle strobe. The block captures the character into a single holding register and raises an active-high interrupt request. The request stays high until the processor reads the port.

The read is the acknowledge. During a selected read, the held character drives data bits 7..0 and the upper lanes drive zero. At the end of that access cycle the request drops. There is no status register and no acknowledge register. Only one character is held, so a newer arrival replaces an unread one.

The port is decoded from the address bus with a mask and a match value. By default this is a single-bit decode on address bit 23, which gives base 0x800000. The request output is meant to be wired to interrupt level 2 of the system priority encoder.

Top module: `irq_byte_port`

## Requirements
- R1: After reset the request output is 0 and the held character is 0, so a first selected read returns 0x0000.
- R2: A cycle with `usr_stb` high captures `usr_char` and sets `irq` to 1, both visible after that clock edge.
- R3: Once set, `irq` stays 1 across any number of cycles until a selected read occurs.
- R4: During a selected read (`bus_req`=1, `bus_rd`=1, address decoded), `bus_rdata[7:0]` equals the held character and `bus_rdata[15:8]` is 0 in that same cycle.
- R5: A selected read with no `usr_stb` in that cycle clears `irq` at the end of that cycle.
- R6: The port is selected only when `bus_addr` bit 23 is 1 (default mask 0x800000, match 0x800000). An access with bit 23 at 0 neither clears `irq` nor returns data.
- R7: A new strobe while `irq` is already 1 replaces the held character with the new one, and `irq` stays 1.
- R8: If a strobe and a selected read fall in the same cycle, the read returns the previously held character, the new character is captured, and `irq` stays 1.
- R9: A selected write (`bus_rd`=0) changes neither the held character nor `irq`.
- R10: Whenever no selected read is in progress, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_char | input | 8 | Character from the user side |
| usr_stb | input | 1 | One-cycle strobe: capture `usr_char` |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 24 | Bus address |
| bus_rdata | output | 16 | Read data, character on bits 7..0 |
| irq | output | 1 | Active-high interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle as the read. The bench drives the inputs just after a falling edge and samples `bus_rdata` one nanosecond later, before the next rising edge. `irq` and the held character change at the rising edge that ends a strobe or read cycle. They are therefore checked one nanosecond after that edge, and the inputs are returned to idle on the following falling edge. The sweep runs every character value through capture, readback and clear. Targeted cycles then cover overwrite, collision, writes and unselected addresses.

// File: rtl/irq_byte_port_pkg.sv
package irq_byte_port_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/inport_decode.sv
module inport_decode
   import irq_byte_port_pkg::*;
#(
   parameter int          ADDR_W = 24,
   parameter logic [23:0] MASK   = 24'h800000,
   parameter logic [23:0] MATCH  = 24'h800000
) (
   input  logic              req,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);
   localparam logic [ADDR_W-1:0] M = MASK[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] V = MATCH[ADDR_W-1:0] & M;

   initial begin
      if (ADDR_W < 1 || ADDR_W > 24) $error("inport_decode: ADDR_W out of range");
      if (M == '0) $error("inport_decode: empty address mask");
   end

   logic sel;
   always_comb begin
      sel  = req && ((addr & M) == V);
      kind = ACC_NONE;
      if (sel) kind = rd ? ACC_READ : ACC_WRITE;
   end
endmodule

// File: rtl/inport_capture.sv
module inport_capture
   import irq_byte_port_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] char_in,
   input  logic              stb,
   input  acc_kind_e         kind,
   output logic [CHAR_W-1:0] held,
   output logic              pend
);
   initial begin
      if (CHAR_W < 1) $error("inport_capture: CHAR_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
         pend <= 1'b0;
      end else if (stb) begin
         held <= char_in;
         pend <= 1'b1;
      end else if (kind == ACC_READ) begin
         pend <= 1'b0;
      end
   end

   a_r2_strobe_raises: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> pend);
   a_r3_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && kind != ACC_READ) |=> pend);
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_READ && !stb) |=> !pend);
   a_r8_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_READ && stb) |=> pend);
   a_r9_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(held));
endmodule

// File: rtl/inport_rdmux.sv
module inport_rdmux
   import irq_byte_port_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int DATA_W = 16
) (
   input  acc_kind_e         kind,
   input  logic [CHAR_W-1:0] held,
   output logic [DATA_W-1:0] rdata
);
   initial begin
      if (CHAR_W > DATA_W) $error("inport_rdmux: character wider than bus");
   end

   logic [CHAR_W-1:0] low;
   assign low = (kind == ACC_READ) ? held : '0;

   generate
      if (DATA_W > CHAR_W) begin : g_pad
         assign rdata = {{(DATA_W-CHAR_W){1'b0}}, low};
      end else begin : g_exact
         assign rdata = low;
      end
   endgenerate
endmodule

// File: rtl/irq_byte_port.sv
module irq_byte_port
   import irq_byte_port_pkg::*;
#(
   parameter int          CHAR_W = 8,
   parameter int          DATA_W = 16,
   parameter int          ADDR_W = 24,
   parameter logic [23:0] MASK   = 24'h800000,
   parameter logic [23:0] MATCH  = 24'h800000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] usr_char,
   input  logic              usr_stb,
   input  logic              bus_req,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   acc_kind_e         kind;
   logic [CHAR_W-1:0] held;

   inport_decode #(.ADDR_W(ADDR_W), .MASK(MASK), .MATCH(MATCH)) u_dec (
      .req(bus_req), .rd(bus_rd), .addr(bus_addr), .kind(kind));

   inport_capture #(.CHAR_W(CHAR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .char_in(usr_char), .stb(usr_stb),
      .kind(kind), .held(held), .pend(irq));

   inport_rdmux #(.CHAR_W(CHAR_W), .DATA_W(DATA_W)) u_mux (
      .kind(kind), .held(held), .rdata(bus_rdata));

   a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_rd) |-> bus_rdata == '0);
   a_r6_unselected_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !usr_stb && !(bus_req && bus_addr[ADDR_W-1])) |=> irq);
endmodule

// File: tb/irq_byte_port_tb.sv
module irq_byte_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  usr_char = '0;
   logic        usr_stb = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_rd = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [15:0] bus_rdata;
   logic        irq;
   int          errs = 0;
   int          checks = 0;

   localparam logic [23:0] PORT = 24'h800000;

   always #2 clk = ~clk;

   irq_byte_port u_dut (.clk(clk), .rst_n(rst_n), .usr_char(usr_char),
      .usr_stb(usr_stb), .bus_req(bus_req), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      usr_stb = 0; bus_req = 0; bus_rd = 0; bus_addr = '0;
   endtask

   task automatic strobe(input logic [7:0] c);
      @(negedge clk);
      usr_char = c; usr_stb = 1;
      @(posedge clk); #1;
      idle();
   endtask

   // drive one access; check rdata in-cycle, irq after the edge
   task automatic access(input string req, input logic rd, input logic [23:0] a,
                         input logic [15:0] exp_data, input logic exp_irq);
      @(negedge clk);
      bus_req = 1; bus_rd = rd; bus_addr = a;
      #1 chk(req, bus_rdata, exp_data);
      @(posedge clk); #1;
      chk(req, {15'd0, irq}, {15'd0, exp_irq});
      idle();
   endtask

   initial begin
      #400000;
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      #1 chk("R1", {15'd0, irq}, 16'd0);
      chk("R10", bus_rdata, 16'd0);
      access("R1", 1, PORT, 16'h0000, 0);

      // R2 R4 R5 sweep all characters
      for (int v = 0; v < 256; v++) begin
         strobe(v[7:0]);
         chk("R2", {15'd0, irq}, 16'd1);
         access("R4", 1, PORT | 24'h00_0F0F, {8'h00, v[7:0]}, 0);
      end

      // R3 hold across idle cycles and unrelated accesses
      strobe(8'h41);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         bus_req = k[0]; bus_rd = 1; bus_addr = 24'h7FFFFF;
         #1 chk("R10", bus_rdata, 16'd0);
         @(posedge clk); #1 chk("R3", {15'd0, irq}, 16'd1);
      end
      idle();
      // R6 unselected read does not clear
      access("R6", 1, 24'h400000, 16'h0000, 1);
      // R9 write ignored
      access("R9", 0, PORT, 16'h0000, 1);
      // R7 overwrite while pending
      strobe(8'h5A);
      chk("R7", {15'd0, irq}, 16'd1);
      // R8 collision
      @(negedge clk);
      usr_char = 8'hC3; usr_stb = 1; bus_req = 1; bus_rd = 1; bus_addr = PORT;
      #1 chk("R8", bus_rdata, 16'h005A);
      @(posedge clk); #1 chk("R8", {15'd0, irq}, 16'd1);
      idle();
      access("R8", 1, PORT, 16'h00C3, 0);
      // R9 write after clear leaves held byte and irq
      access("R9", 0, PORT, 16'h0000, 0);
      access("R9", 1, PORT, 16'h00C3, 0);
      // R5 second read keeps irq low
      access("R5", 1, PORT, 16'h00C3, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule